// File: doc/BRIEF.md
# Prescaled Periodic Interval Timer

This block raises a periodic interrupt for a processor. A small prescaler divides the processor clock by a programmable factor. Each time the prescaler wraps, a 16-bit down-counter steps once. When the counter is already at zero on such a step, the timer emits a one-cycle interrupt pulse and reloads the counter from a separate period register. Because of this reload, the interrupt repeats with no software involvement.

Software reaches the timer through a small register port with one shared address. Through that port it sets the scale, the live count and the period, switches counting on and off, and reads all of them back. With scale S and period P, the interrupt recurs every (P+1)*(S+1) clock cycles once the first reload has happened.

Top module: `interval_timer`

## Requirements
- R1: After reset (active-low `rst_n`), enable is 0, the scale, count and period registers all read 0, and `irq` is 0.
- R2: The register addresses are 0 = control (bit 0 is enable, all other bits read 0), 1 = scale (8 bits, taken from `wr_data[7:0]`, read back zero-extended), 2 = count (16 bits) and 3 = period (16 bits). `rd_data` shows the addressed register combinationally, and a write is visible on the cycle after its clock edge.
- R3: While enable is 0, neither the count nor the prescaler phase changes.
- R4: With scale S, the enabled prescaler wraps once every S+1 cycles. The count steps once at each wrap, so a scale of 0 steps the count on every cycle.
- R5: A step taken while the count is 0 reloads the count from the period register and drives `irq` high for the one cycle that follows.
- R6: With period P and scale S, consecutive `irq` pulses are (P+1)*(S+1) cycles apart after the first reload. This also holds in the limit P=0, S=0, where `irq` is high on every cycle.
- R7: A write to the count register sets the count on the next edge and wins over a step or a reload in that cycle.
- R8: A write to the scale register also restarts the prescaler from the new value, so the next step comes S+1 enabled cycles after the write.
- R9: A write to the period register leaves the live count untouched. The new period is used at the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | 2 | Register select for both reads and writes |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data of the selected register |
| irq | output | 1 | Interrupt pulse, registered |

## Verification
Register writes appear on `rd_data` one clock after the edge that takes them. A count step is visible one clock after the enabled cycle in which the prescaler sits at zero. The interrupt is high during the clock that follows the edge on which the reload happens. The bench steps a behavioural model at every rising edge and compares `rd_data` and `irq` at the next falling edge, so each result is checked in exactly the cycle it is due. The spacing between interrupt pulses is measured separately in cycles against (P+1)*(S+1).

// File: rtl/timer_pkg.sv
`timescale 1ns/1ps
// Package: shared register-select encoding for the interval timer.
// Assumes a two-bit register address space with four registers.
package timer_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_CTRL   = 2'd0,
        SEL_SCALE  = 2'd1,
        SEL_COUNT  = 2'd2,
        SEL_PERIOD = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/timer_regs.sv
`timescale 1ns/1ps
// Module: timer_regs
// Holds the control, scale and period registers. Decodes writes into
// load strobes for the prescaler and the counter, and muxes read data.
// Assumes CNT_W > SCALE_W and that the live count is kept elsewhere.
module timer_regs
    import timer_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int SCALE_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [CNT_W-1:0]   wr_data,
    input  logic [CNT_W-1:0]   count_val,
    output logic               enable,
    output logic [SCALE_W-1:0] scale,
    output logic [CNT_W-1:0]   period,
    output logic               scale_wr,
    output logic               count_wr,
    output logic [CNT_W-1:0]   rd_data
);
    localparam int PAD_SCALE = CNT_W - SCALE_W;
    localparam int PAD_CTRL  = CNT_W - 1;

    reg_sel_e sel;
    logic     ctrl_wr;
    logic     period_wr;

    // Cast the raw address into the register-select encoding.
    always_comb sel = reg_sel_e'(addr);

    // Decode the write strobe per register.
    always_comb begin
        ctrl_wr   = wr_en && (sel == SEL_CTRL);
        scale_wr  = wr_en && (sel == SEL_SCALE);
        count_wr  = wr_en && (sel == SEL_COUNT);
        period_wr = wr_en && (sel == SEL_PERIOD);
    end

    // Store the enable, scale and period registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable <= 1'b0;
            scale  <= '0;
            period <= '0;
        end else begin
            if (ctrl_wr)   enable <= wr_data[0];
            if (scale_wr)  scale  <= wr_data[SCALE_W-1:0];
            if (period_wr) period <= wr_data;
        end
    end

    // Select the register shown on the read port.
    always_comb begin
        unique case (sel)
            SEL_CTRL:   rd_data = {{PAD_CTRL{1'b0}}, enable};
            SEL_SCALE:  rd_data = {{PAD_SCALE{1'b0}}, scale};
            SEL_COUNT:  rd_data = count_val;
            SEL_PERIOD: rd_data = period;
            default:    rd_data = '0;
        endcase
    end
endmodule

// File: rtl/timer_prescaler.sv
`timescale 1ns/1ps
// Module: timer_prescaler
// Down-counts from the scale value while enabled and issues a tick in
// each enabled cycle in which its phase is zero. The tick rate is one in
// scale+1. A load restarts the phase. Frozen while disabled.
module timer_prescaler #(
    parameter int SCALE_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic [SCALE_W-1:0] scale,
    input  logic               load,
    input  logic [SCALE_W-1:0] load_val,
    output logic               tick
);
    logic [SCALE_W-1:0] phase;

    // Flag the terminal count of the prescaler.
    always_comb tick = enable && (phase == '0);

    // Advance or restart the prescaler phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (load) begin
            phase <= load_val;
        end else if (enable) begin
            phase <= (phase == '0) ? scale : phase - 1'b1;
        end
    end
endmodule

// File: rtl/timer_counter.sv
`timescale 1ns/1ps
// Module: timer_counter
// The main down-counter. It steps on each prescaler tick. A tick at zero
// reloads it from the period and registers a one-cycle interrupt pulse.
// A software load takes priority over stepping.
module timer_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] period,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             irq
);
    logic at_zero;

    // Detect the reload condition.
    always_comb at_zero = (count == '0);

    // Update the count from a load, a reload or a step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (tick) begin
            count <= at_zero ? period : count - 1'b1;
        end
    end

    // Register the interrupt pulse for the reload step.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= tick && at_zero;
    end
endmodule

// File: rtl/interval_timer.sv
`timescale 1ns/1ps
// Module: interval_timer (top)
// Prescaled periodic interval timer with a register port.
// Assumes the synchronous active-low reset is held for at least one edge.
module interval_timer
    import timer_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int SCALE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [CNT_W-1:0]  rd_data,
    output logic              irq
);
    logic               enable;
    logic [SCALE_W-1:0] scale;
    logic [CNT_W-1:0]   period;
    logic [CNT_W-1:0]   count;
    logic               scale_wr;
    logic               count_wr;
    logic               tick;

    timer_regs #(.CNT_W(CNT_W), .SCALE_W(SCALE_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .count_val(count), .enable(enable),
        .scale(scale), .period(period), .scale_wr(scale_wr),
        .count_wr(count_wr), .rd_data(rd_data)
    );

    timer_prescaler #(.SCALE_W(SCALE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .enable(enable), .scale(scale),
        .load(scale_wr), .load_val(wr_data[SCALE_W-1:0]), .tick(tick)
    );

    timer_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .period(period),
        .load(count_wr), .load_val(wr_data), .count(count), .irq(irq)
    );
endmodule

// File: rtl/interval_timer_checker.sv
`timescale 1ns/1ps
// Module: interval_timer_checker
// Temporal properties of the interval timer, attached by bind.
module interval_timer_checker #(
    parameter int CNT_W   = 16,
    parameter int SCALE_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [1:0]         addr,
    input logic [CNT_W-1:0]   wr_data,
    input logic [CNT_W-1:0]   rd_data,
    input logic               irq,
    input logic               enable,
    input logic               tick,
    input logic [SCALE_W-1:0] scale,
    input logic [CNT_W-1:0]   period,
    input logic [CNT_W-1:0]   count
);
    logic w_count, w_scale, w_period;
    always_comb begin
        w_count  = wr_en && (addr == 2'd2);
        w_scale  = wr_en && (addr == 2'd1);
        w_period = wr_en && (addr == 2'd3);
    end

    AST_NO_TICK_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> !tick); // R3
    AST_FROZEN_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !w_count) |=> $stable(count)); // R3
    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && count != '0 && !w_count) |=> (count == $past(count) - 1'b1)); // R4
    AST_RELOAD_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && count == '0 && !w_count) |=> (irq && count == $past(period))); // R5
    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(enable)); // R5
    AST_COUNT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        w_count |=> (count == $past(wr_data))); // R7
    AST_SCALE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        w_scale |=> (scale == $past(wr_data[SCALE_W-1:0]))); // R2
    AST_PERIOD_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (w_period && !tick && !w_count) |=> $stable(count)); // R9
    AST_READ_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 2'd2) |-> (rd_data == count)); // R2
endmodule

bind interval_timer interval_timer_checker #(.CNT_W(CNT_W), .SCALE_W(SCALE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .irq(irq), .enable(enable), .tick(tick),
    .scale(scale), .period(period), .count(count)
);

// File: tb/interval_timer_test.sv
`timescale 1ns/1ps
module interval_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic [15:0] rd_data;
    logic        irq;

    int total = 0, bad = 0, cyc = 0, last_irq = -1, exp_gap = 0;
    string tag = "R1";
    int m_en = 0, m_scale = 0, m_pre = 0, m_cnt = 0, m_per = 0;
    int m_irq = 0;

    always #2.5 clk = ~clk;

    interval_timer uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
                        .wr_data(wr_data), .rd_data(rd_data), .irq(irq));

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic int model_read(int a);
        case (a)
            0: return m_en;
            1: return m_scale;
            2: return m_cnt;
            default: return m_per;
        endcase
    endfunction

    task automatic model_update(bit we, int a, int d);
        bit tk;
        tk = (m_en != 0) && (m_pre == 0);
        m_irq = (tk && m_cnt == 0) ? 1 : 0;
        if (m_en != 0) m_pre = (m_pre == 0) ? m_scale : m_pre - 1;
        if (tk) m_cnt = (m_cnt == 0) ? m_per : m_cnt - 1;
        if (we) begin
            case (a)
                0: m_en = d & 1;
                1: begin m_scale = d & 255; m_pre = d & 255; end
                2: m_cnt = d & 16'hFFFF;
                default: m_per = d & 16'hFFFF;
            endcase
        end
    endtask

    task automatic step(bit we, int a, int d);
        wr_en = we; addr = a[1:0]; wr_data = d[15:0];
        @(posedge clk);
        model_update(we, a, d);
        cyc++;
        @(negedge clk);
        chk({tag, " rd_data"}, int'(rd_data), model_read(a));
        chk({tag, " irq"}, int'(irq), m_irq);
        if (irq) begin
            if (exp_gap > 0 && last_irq >= 0)
                chk({tag, " irq interval"}, cyc - last_irq, exp_gap);
            last_irq = cyc;
        end
    endtask

    task automatic wr(int a, int d); step(1'b1, a, d); endtask
    task automatic idle(int n, int a);
        for (int i = 0; i < n; i++) step(1'b0, a, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset state on every register and on irq
        repeat (3) @(posedge clk);
        @(negedge clk);
        for (int a = 0; a < 4; a++) begin
            addr = a[1:0];
            #0.5;
            chk("R1 reset read", int'(rd_data), 0);
        end
        chk("R1 reset irq", int'(irq), 0);
        rst_n = 1'b1;
        idle(2, 2);

        // R2: readback, scale truncation, control bit 0 only
        tag = "R2";
        wr(1, 16'hABCD);
        chk("R2 scale low byte", int'(rd_data), 16'h00CD);
        wr(3, 16'h1234);
        wr(0, 16'hFFFE);
        chk("R2 ctrl bit0", int'(rd_data), 0);
        idle(1, 1);
        idle(1, 3);

        // R3: frozen while disabled, including mid-prescale
        tag = "R3";
        wr(2, 5); wr(1, 3); wr(3, 9);
        idle(6, 2);
        chk("R3 count frozen", int'(rd_data), 5);
        wr(0, 1); idle(2, 2);
        wr(0, 0); idle(8, 2);
        wr(0, 1); idle(12, 2);

        // R4 R5 R6: scale 2, period 4 -> interval 15
        tag = "R4 R5 R6 s2p4";
        wr(0, 0); wr(1, 2); wr(3, 4); wr(2, 0);
        exp_gap = 15; last_irq = -1;
        wr(0, 1); idle(70, 2);

        // R4 R6: scale 0, period 0 -> irq every cycle
        tag = "R4 R6 s0p0";
        exp_gap = 0;
        wr(0, 0); wr(1, 0); wr(3, 0); wr(2, 0);
        exp_gap = 1; last_irq = -1;
        wr(0, 1); idle(8, 2);

        // R6: scale 255, period 2 -> interval 768
        tag = "R6 s255p2";
        exp_gap = 0;
        wr(0, 0); wr(1, 255); wr(3, 2);
        exp_gap = 768; last_irq = -1;
        wr(0, 1); idle(2400, 2);

        // R7: count write immediate, beats stepping
        tag = "R7";
        exp_gap = 0;
        wr(0, 0); wr(1, 0); wr(3, 6); wr(2, 3);
        wr(0, 1); idle(3, 2);
        wr(2, 100);
        chk("R7 write immediate", int'(rd_data), 100);
        idle(4, 2);
        wr(2, 0); wr(2, 9);
        chk("R7 write over reload", int'(rd_data), 9);
        idle(4, 2);

        // R8: scale write restarts prescaler
        tag = "R8";
        wr(2, 50); wr(1, 3); idle(10, 2);
        wr(1, 0); idle(5, 2);
        wr(1, 5); idle(13, 2);

        // R9: period write leaves count alone
        tag = "R9";
        wr(0, 0); wr(2, 40); wr(3, 7);
        idle(1, 2);
        chk("R9 count kept", int'(rd_data), 40);
        wr(1, 0); wr(0, 1); wr(3, 200); idle(45, 2);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule